// File: doc/BRIEF.md
# Paged Four-Channel Byte DMA Engine

This block moves single bytes between four peripheral data ports and a memory bus. Software reaches every channel through one narrow register window. A bank-select register picks the channel that the window currently addresses. Each channel keeps a direction, a set of option flags, a 24-bit byte count, a 12-bit in-page offset, a tag, a free-use width byte and its own 256-entry table of 16-bit page numbers. The channel's tag picks which table entry is in use.

When a channel is armed and its peripheral raises its request, the engine performs one byte transfer in that same cycle, combinationally on the ports. It drives the memory address, the strobe and the data, and it acknowledges the peripheral. On the next clock edge it advances the offset and counts the transfer down. A transfer that crosses a page end moves on to the next table entry. When the count runs out, the channel disarms itself and can flag an interrupt. Channel interrupts and external interrupt lines are merged into a single registered interrupt output.

Top module: `pdma_engine`

## Requirements
- R1: After reset every channel field, the bank select, the pending-interrupt bits and `int_out` read as zero, and no acknowledge or memory strobe is driven.
- R2: Register addresses 0 to 8 act only on the channel named by the bank-select register (address 9, low 2 bits). Tag (address 4) and width (address 5) read back what was written. Address 10 is read-only.
- R3: The count is accessed as three bytes: address 1 holds bits 7:0, address 2 holds bits 15:8 and address 3 holds bits 23:16. Writing one byte leaves the other two unchanged.
- R4: The offset low byte is at address 6. The high part is at address 7, which stores only data bits 3:0 and reads back with bits 7:4 as zero.
- R5: Address 8 is a 16-bit port onto the selected channel's table entry at index = its current tag. A write updates only the byte lanes whose `reg_be` bit is set (bit 0 for data 7:0, bit 1 for data 15:8).
- R6: Control byte (address 0) fields: bit0 arm, bit1 direction (1 = peripheral to memory), bit2 clear, bit3 interrupt-on-terminal, bit4 pad, bit5 hold-address, bit6 address bit 28, bit7 count-exhausted (read-only). A transfer drives `mem_addr` = {bit6, table entry, offset}. With direction 1 it asserts `mem_we` with the peripheral's byte. With direction 0 it asserts `mem_re` and returns `mem_rdata` on `dev_wdata`.
- R7: After each memory transfer the offset increments, unless hold-address is set. An increment out of 0xFFF wraps the offset to 0 and increments the tag modulo 256.
- R8: Each memory transfer decrements the count. The transfer that reaches zero disarms the channel and sets count-exhausted. An armed channel whose count is already zero does the same on the next edge with no transfer. Either way the channel's pending-interrupt bit is set if interrupt-on-terminal is enabled.
- R9: At most one `dev_ack` bit is high per cycle. It goes to the lowest-numbered channel whose request is high and which is armed with a nonzero count or is padding.
- R10: Writing the control byte with bit 2 set zeroes that channel's count and offset, clears count-exhausted and leaves it disarmed. Bit 2 always reads back as 0.
- R11: A channel that is disarmed, with count-exhausted, pad set and direction 0, acknowledges each request with `dev_wdata` = 0 and no memory strobe.
- R12: `int_out` is the registered OR of all pending-interrupt bits and `irq_in`, one cycle late. Address 10 bits 3:0 show the pending bits. Any control-byte write clears that channel's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data (bits 15:8 used by the table port only) |
| reg_be | input | 2 | Byte-lane enables for table-port writes |
| reg_rdata | output | 16 | Register read data, combinational |
| dreq | input | 4 | Per-channel transfer request |
| dev_rdata | input | 32 | Per-channel peripheral byte, channel n at bits 8n+7:8n |
| dev_ack | output | 4 | One-hot transfer acknowledge |
| dev_wdata | output | 8 | Byte delivered to the acknowledged peripheral |
| mem_addr | output | 29 | Memory byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle |
| irq_in | input | N_EXT | External interrupt lines |
| int_out | output | 1 | Combined interrupt |

## Verification
The bench uses the default of two external interrupt lines together with the fixed four channels, 256-entry tables and 12-bit offsets. The offset is narrow and the count is loaded with small values, so a page wrap and the tag step that follows can be reached in three transfers by presetting the offset to 0xFFE. Count exhaustion, padding and a zero-count arm can each be reached within a few cycles. With four channels, two simultaneous requesters are enough to show the priority order and the hand-over once the winner runs dry.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int NCH    = 4;
    localparam int SEL_W  = $clog2(NCH);
    localparam int CNT_W  = 24;
    localparam int TAG_W  = 8;
    localparam int OFS_W  = 12;
    localparam int MAP_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 1 + MAP_W + OFS_W;

    typedef enum logic [3:0] {
        RA_CTRL = 4'd0,
        RA_CNT0 = 4'd1,
        RA_CNT1 = 4'd2,
        RA_CNT2 = 4'd3,
        RA_TAG  = 4'd4,
        RA_WID  = 4'd5,
        RA_OFS0 = 4'd6,
        RA_OFS1 = 4'd7,
        RA_MAP  = 4'd8,
        RA_BANK = 4'd9,
        RA_GST  = 4'd10
    } reg_sel_e;

    typedef struct packed {
        logic              armed;
        logic              to_mem;
        logic              irq_en;
        logic              pad;
        logic              hold;
        logic              hi_bit;
        logic              spent;
        logic [CNT_W-1:0]  cnt;
        logic [TAG_W-1:0]  tag;
        logic [BYTE_W-1:0] wid;
        logic [OFS_W-1:0]  ofs;
    } chan_t;
endpackage

// File: rtl/pdma_prio_arb.sv
module pdma_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
        gnt = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/pdma_pagemap.sv
module pdma_pagemap #(
    parameter int NCH   = 4,
    parameter int TAG_W = 8,
    parameter int ENT_W = 16
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ENT_W/8-1:0]      wbe,
    input  logic [$clog2(NCH)-1:0]  wch,
    input  logic [TAG_W-1:0]        wtag,
    input  logic [ENT_W-1:0]        wdata,
    input  logic [$clog2(NCH)-1:0]  ach,
    input  logic [TAG_W-1:0]        atag,
    output logic [ENT_W-1:0]        adata,
    input  logic [$clog2(NCH)-1:0]  bch,
    input  logic [TAG_W-1:0]        btag,
    output logic [ENT_W-1:0]        bdata
);
    localparam int LANES = ENT_W / 8;
    localparam int DEPTH = NCH << TAG_W;

    logic [ENT_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (wbe[b]) tbl[{wch, wtag}][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    assign adata = tbl[{ach, atag}];
    assign bdata = tbl[{bch, btag}];
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int N_EXT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [3:0]            reg_addr,
    input  logic [MAP_W-1:0]      reg_wdata,
    input  logic [MAP_W/8-1:0]    reg_be,
    output logic [MAP_W-1:0]      reg_rdata,
    input  logic [NCH-1:0]        dreq,
    input  logic [NCH*BYTE_W-1:0] dev_rdata,
    output logic [NCH-1:0]        dev_ack,
    output logic [BYTE_W-1:0]     dev_wdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_re,
    output logic                  mem_we,
    output logic [BYTE_W-1:0]     mem_wdata,
    input  logic [BYTE_W-1:0]     mem_rdata,
    input  logic [N_EXT-1:0]      irq_in,
    output logic                  int_out
);
    localparam int OFS_HI = OFS_W - 8;

    typedef struct packed {
        chan_t [NCH-1:0]  ch;
        logic [NCH-1:0]   pend;
        logic [SEL_W-1:0] bank;
        logic             intr;
    } state_t;

    state_t st_q, st_d;

    reg_sel_e         ra;
    chan_t            cur;
    logic [NCH-1:0]   live, padding, req, gnt;
    logic [SEL_W-1:0] gidx;
    logic             gany, gpad, do_mem, g_to_mem;
    logic [MAP_W-1:0] map_x, map_r;

    assign ra  = reg_sel_e'(reg_addr);
    assign cur = st_q.ch[st_q.bank];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            live[i]    = st_q.ch[i].armed && (st_q.ch[i].cnt != '0);
            padding[i] = st_q.ch[i].pad && !st_q.ch[i].to_mem &&
                         st_q.ch[i].spent && !st_q.ch[i].armed;
            req[i]     = dreq[i] && (live[i] || padding[i]);
        end
    end

    pdma_prio_arb #(.N(NCH)) u_arb (
        .req (req),
        .gnt (gnt),
        .idx (gidx),
        .any (gany)
    );

    pdma_pagemap #(.NCH(NCH), .TAG_W(TAG_W), .ENT_W(MAP_W)) u_map (
        .clk   (clk),
        .we    (reg_we && (ra == RA_MAP)),
        .wbe   (reg_be),
        .wch   (st_q.bank),
        .wtag  (cur.tag),
        .wdata (reg_wdata),
        .ach   (gidx),
        .atag  (st_q.ch[gidx].tag),
        .adata (map_x),
        .bch   (st_q.bank),
        .btag  (cur.tag),
        .bdata (map_r)
    );

    assign gpad     = padding[gidx];
    assign do_mem   = gany && !gpad;
    assign g_to_mem = st_q.ch[gidx].to_mem;

    // transfer side, combinational on the ports
    assign dev_ack   = gnt;
    assign mem_addr  = {st_q.ch[gidx].hi_bit, map_x, st_q.ch[gidx].ofs};
    assign mem_we    = do_mem && g_to_mem;
    assign mem_re    = do_mem && !g_to_mem;
    assign mem_wdata = dev_rdata[int'(gidx)*BYTE_W +: BYTE_W];
    assign dev_wdata = mem_re ? mem_rdata : '0;
    assign int_out   = st_q.intr;

    // next-state
    always_comb begin
        st_d = st_q;

        // armed with nothing left: finish without a transfer
        for (int i = 0; i < NCH; i++) begin
            if (st_q.ch[i].armed && (st_q.ch[i].cnt == '0)) begin
                st_d.ch[i].armed = 1'b0;
                st_d.ch[i].spent = 1'b1;
                if (st_q.ch[i].irq_en) st_d.pend[i] = 1'b1;
            end
        end

        if (do_mem) begin
            st_d.ch[gidx].cnt = st_q.ch[gidx].cnt - CNT_W'(1);
            if (!st_q.ch[gidx].hold) begin
                st_d.ch[gidx].ofs = st_q.ch[gidx].ofs + OFS_W'(1);
                if (st_q.ch[gidx].ofs == '1)
                    st_d.ch[gidx].tag = st_q.ch[gidx].tag + TAG_W'(1);
            end
            if (st_q.ch[gidx].cnt == CNT_W'(1)) begin
                st_d.ch[gidx].armed = 1'b0;
                st_d.ch[gidx].spent = 1'b1;
                if (st_q.ch[gidx].irq_en) st_d.pend[gidx] = 1'b1;
            end
        end

        if (reg_we) begin
            case (ra)
                RA_CTRL: begin
                    st_d.ch[st_q.bank].armed  = reg_wdata[0];
                    st_d.ch[st_q.bank].to_mem = reg_wdata[1];
                    st_d.ch[st_q.bank].irq_en = reg_wdata[3];
                    st_d.ch[st_q.bank].pad    = reg_wdata[4];
                    st_d.ch[st_q.bank].hold   = reg_wdata[5];
                    st_d.ch[st_q.bank].hi_bit = reg_wdata[6];
                    st_d.pend[st_q.bank]      = 1'b0;
                    if (reg_wdata[2]) begin
                        st_d.ch[st_q.bank].armed = 1'b0;
                        st_d.ch[st_q.bank].spent = 1'b0;
                        st_d.ch[st_q.bank].cnt   = '0;
                        st_d.ch[st_q.bank].ofs   = '0;
                    end
                end
                RA_CNT0: st_d.ch[st_q.bank].cnt[7:0]   = reg_wdata[7:0];
                RA_CNT1: st_d.ch[st_q.bank].cnt[15:8]  = reg_wdata[7:0];
                RA_CNT2: st_d.ch[st_q.bank].cnt[23:16] = reg_wdata[7:0];
                RA_TAG:  st_d.ch[st_q.bank].tag        = reg_wdata[TAG_W-1:0];
                RA_WID:  st_d.ch[st_q.bank].wid        = reg_wdata[BYTE_W-1:0];
                RA_OFS0: st_d.ch[st_q.bank].ofs[7:0]   = reg_wdata[7:0];
                RA_OFS1: st_d.ch[st_q.bank].ofs[OFS_W-1:8] = reg_wdata[OFS_HI-1:0];
                RA_BANK: st_d.bank = reg_wdata[SEL_W-1:0];
                default: ;
            endcase
        end

        st_d.intr = (|st_q.pend) || (|irq_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read window
    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_CTRL: reg_rdata[7:0] = {cur.spent, cur.hi_bit, cur.hold, cur.pad,
                                       cur.irq_en, 1'b0, cur.to_mem, cur.armed};
            RA_CNT0: reg_rdata[7:0] = cur.cnt[7:0];
            RA_CNT1: reg_rdata[7:0] = cur.cnt[15:8];
            RA_CNT2: reg_rdata[7:0] = cur.cnt[23:16];
            RA_TAG:  reg_rdata[TAG_W-1:0] = cur.tag;
            RA_WID:  reg_rdata[BYTE_W-1:0] = cur.wid;
            RA_OFS0: reg_rdata[7:0] = cur.ofs[7:0];
            RA_OFS1: reg_rdata[OFS_HI-1:0] = cur.ofs[OFS_W-1:8];
            RA_MAP:  reg_rdata = map_r;
            RA_BANK: reg_rdata[SEL_W-1:0] = st_q.bank;
            RA_GST:  reg_rdata[NCH-1:0] = st_q.pend;
            default: ;
        endcase
    end

    // R9
    ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack) && ((dev_ack & ~dreq) == '0));

    // R11
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0 && !mem_re && !mem_we) |-> dev_wdata == '0);

    // R12
    int_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int_out == $past((|st_q.pend) || (|irq_in)));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_ack[c] && (mem_re || mem_we) && !reg_we)
            |=> st_q.ch[c].cnt == $past(st_q.ch[c].cnt) - CNT_W'(1));

        // R8
        spent_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.ch[c].spent) |-> (!st_q.ch[c].armed || $past(reg_we)));

        // R10
        clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && ra == RA_CTRL && reg_wdata[2] && st_q.bank == SEL_W'(c))
            |=> (st_q.ch[c].cnt == '0 && st_q.ch[c].ofs == '0 &&
                 !st_q.ch[c].spent && !st_q.ch[c].armed));
    end
endmodule

// File: tb/pdma_engine_bench.sv
module pdma_engine_bench;
    localparam int NE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd9;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_be = 2'b11;
    logic [15:0] reg_rdata;
    logic [3:0]  dreq = '0;
    logic [31:0] dev_rdata = 32'hD3C2B1A0;
    logic [3:0]  dev_ack;
    logic [7:0]  dev_wdata;
    logic [28:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [NE-1:0] irq_in = '0;
    logic        int_out;
    bit          done = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ mem_addr[19:12] ^ 8'h3C;

    pdma_engine #(.N_EXT(NE)) u_pdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .dreq(dreq), .dev_rdata(dev_rdata), .dev_ack(dev_ack),
        .dev_wdata(dev_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_in(irq_in), .int_out(int_out)
    );

    int vecs = 0, miss = 0;

    // reference state
    int m_en[4], m_dir[4], m_ie[4], m_apad[4], m_afix[4], m_a28[4], m_tcz[4];
    int m_cnt[4], m_ofs[4], m_tag[4], m_wid[4];
    int mp[1024];
    int m_pend = 0, m_sel = 0, m_intq = 0;
    int cur_g = -1;
    bit cur_pad = 0;

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int exp_read(int a);
        int s = m_sel;
        case (a)
            0: return (m_tcz[s] << 7) | (m_a28[s] << 6) | (m_afix[s] << 5) |
                      (m_apad[s] << 4) | (m_ie[s] << 3) | (m_dir[s] << 1) | m_en[s];
            1: return m_cnt[s] & 255;
            2: return (m_cnt[s] >> 8) & 255;
            3: return (m_cnt[s] >> 16) & 255;
            4: return m_tag[s];
            5: return m_wid[s];
            6: return m_ofs[s] & 255;
            7: return m_ofs[s] >> 8;
            8: return mp[s*256 + m_tag[s]];
            9: return m_sel;
            10: return m_pend;
            default: return 0;
        endcase
    endfunction

    function automatic string rlabel(int a);
        case (a)
            0: return "R8 R10 control read";
            1, 2, 3: return "R3 count read";
            4, 5, 9: return "R2 banked read";
            6, 7: return "R4 offset read";
            8: return "R5 table read";
            10: return "R12 pending read";
            default: return "R2 unused read";
        endcase
    endfunction

    task automatic eval_now();
        int g;
        int a;
        bit pd_g;
        g = -1;
        pd_g = 0;
        for (int i = 3; i >= 0; i--) begin
            bit act;
            bit pd;
            act = (m_en[i] != 0) && (m_cnt[i] != 0);
            pd  = (m_apad[i] != 0) && (m_dir[i] == 0) && (m_tcz[i] != 0) && (m_en[i] == 0);
            if (dreq[i] && (act || pd)) begin
                g = i;
                pd_g = pd;
            end
        end
        cur_g = g;
        cur_pad = pd_g;
        check("R9 acknowledge", {28'd0, dev_ack}, (g < 0) ? 0 : (1 << g));
        if (g >= 0 && pd_g) begin
            check("R11 pad byte", {24'd0, dev_wdata}, 0);
            check("R11 no memory strobe", {30'd0, mem_re, mem_we}, 0);
        end else if (g >= 0) begin
            a = (m_a28[g] << 28) | (mp[g*256 + m_tag[g]] << 12) | m_ofs[g];
            check("R6 R7 address", {3'd0, mem_addr}, a);
            check("R6 strobes", {30'd0, mem_re, mem_we}, (m_dir[g] != 0) ? 1 : 2);
            if (m_dir[g] != 0)
                check("R6 memory write data", {24'd0, mem_wdata}, dev_rdata[g*8 +: 8]);
            else
                check("R6 peripheral data", {24'd0, dev_wdata},
                      (a & 255) ^ ((a >> 12) & 255) ^ 8'h3C);
        end else begin
            check("R6 idle strobes", {30'd0, mem_re, mem_we}, 0);
        end
        check("R12 interrupt out", {31'd0, int_out}, m_intq);
        check(rlabel(int'(reg_addr)), {16'd0, reg_rdata}, exp_read(int'(reg_addr)));
    endtask

    task automatic step_model();
        int p_old;
        int s;
        int w;
        p_old = m_pend;
        for (int i = 0; i < 4; i++) begin
            if (m_en[i] != 0 && m_cnt[i] == 0) begin
                m_en[i] = 0; m_tcz[i] = 1;
                if (m_ie[i] != 0) m_pend |= (1 << i);
            end
        end
        if (cur_g >= 0 && !cur_pad) begin
            m_cnt[cur_g] = m_cnt[cur_g] - 1;
            if (m_afix[cur_g] == 0) begin
                if (m_ofs[cur_g] == 4095) begin
                    m_ofs[cur_g] = 0;
                    m_tag[cur_g] = (m_tag[cur_g] + 1) & 255;
                end else m_ofs[cur_g] = m_ofs[cur_g] + 1;
            end
            if (m_cnt[cur_g] == 0) begin
                m_en[cur_g] = 0; m_tcz[cur_g] = 1;
                if (m_ie[cur_g] != 0) m_pend |= (1 << cur_g);
            end
        end
        if (reg_we) begin
            s = m_sel;
            w = int'(reg_wdata);
            case (int'(reg_addr))
                0: begin
                    m_en[s] = w & 1; m_dir[s] = (w >> 1) & 1; m_ie[s] = (w >> 3) & 1;
                    m_apad[s] = (w >> 4) & 1; m_afix[s] = (w >> 5) & 1; m_a28[s] = (w >> 6) & 1;
                    m_pend &= ~(1 << s);
                    if ((w & 4) != 0) begin
                        m_en[s] = 0; m_tcz[s] = 0; m_cnt[s] = 0; m_ofs[s] = 0;
                    end
                end
                1: m_cnt[s] = (m_cnt[s] & 'hFFFF00) | (w & 255);
                2: m_cnt[s] = (m_cnt[s] & 'hFF00FF) | ((w & 255) << 8);
                3: m_cnt[s] = (m_cnt[s] & 'h00FFFF) | ((w & 255) << 16);
                4: m_tag[s] = w & 255;
                5: m_wid[s] = w & 255;
                6: m_ofs[s] = (m_ofs[s] & 'hF00) | (w & 255);
                7: m_ofs[s] = (m_ofs[s] & 'h0FF) | ((w & 15) << 8);
                8: begin
                    if (reg_be[0]) mp[s*256 + m_tag[s]] = (mp[s*256 + m_tag[s]] & 'hFF00) | (w & 255);
                    if (reg_be[1]) mp[s*256 + m_tag[s]] = (mp[s*256 + m_tag[s]] & 'h00FF) | (w & 'hFF00);
                end
                9: m_sel = w & 3;
                default: ;
            endcase
        end
        m_intq = (p_old != 0 || irq_in != 0) ? 1 : 0;
    endtask

    task automatic cyc();
        #1 eval_now();
        @(posedge clk);
        step_model();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr(int a, int d, int be = 3);
        reg_we = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = 16'(d);
        reg_be = 2'(be);
        cyc();
        reg_we = 1'b0;
        reg_be = 2'b11;
        reg_addr = 4'd9;
    endtask

    task automatic rd(int a);
        reg_addr = 4'(a);
        cyc();
        reg_addr = 4'd9;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_dir[i] = 0; m_ie[i] = 0; m_apad[i] = 0; m_afix[i] = 0;
            m_a28[i] = 0; m_tcz[i] = 0; m_cnt[i] = 0; m_ofs[i] = 0; m_tag[i] = 0; m_wid[i] = 0;
        end
        for (int i = 0; i < 1024; i++) mp[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports
        #1;
        check("R1 no acknowledge", {28'd0, dev_ack}, 0);
        check("R1 no strobes", {30'd0, mem_re, mem_we}, 0);
        check("R1 interrupt low", {31'd0, int_out}, 0);
        check("R1 bank zero", {16'd0, reg_rdata}, 0);
        @(negedge clk);
        for (int a = 0; a < 11; a++) if (a != 8) rd(a);

        // R3 count bytes on channel 1, R2 banking
        wr(9, 1);
        wr(1, 'h01); wr(2, 'h02); wr(3, 'h03);
        rd(1); rd(2); rd(3);
        wr(2, 'hAA);
        rd(1); rd(2); rd(3);
        wr(5, 'h5E); rd(5);
        wr(9, 0); rd(1); rd(2); rd(3); rd(5);

        // R4 offset high keeps four bits
        wr(9, 1);
        wr(6, 'hFE); wr(7, 'hFF);
        rd(6); rd(7);

        // R5 table port with lanes
        wr(4, 5);
        wr(8, 'h1234, 3); rd(8);
        wr(8, 'hABCD, 1); rd(8);
        wr(8, 'hEF00, 2); rd(8);
        wr(4, 6); wr(8, 'h7777, 3); rd(8);
        wr(4, 5); rd(8); rd(4);

        // R6 R7 R8 R12: peripheral to memory with page wrap, ch1
        wr(3, 0); wr(2, 0); wr(1, 3);
        wr(0, 'h0B);
        dreq = 4'b0010;
        idle(5);
        dreq = 4'b0000;
        rd(0); rd(4); rd(6); rd(7); rd(10);
        idle(2);
        wr(0, 'h00); idle(2); rd(10);

        // R9 priority and hold-address: ch0 and ch2 read memory
        wr(9, 0); wr(4, 0); wr(8, 'h0100); wr(1, 2); wr(6, 'h10); wr(0, 'h01);
        wr(9, 2); wr(4, 0); wr(8, 'h0200); wr(1, 2); wr(6, 'h20); wr(0, 'h21);
        dreq = 4'b0101;
        idle(6);
        dreq = 4'b0000;
        rd(0); rd(6);

        // R11 pad on ch3
        wr(9, 3); wr(4, 0); wr(8, 'h0333); wr(1, 1); wr(0, 'h19);
        dreq = 4'b1000;
        idle(4);
        dreq = 4'b1010;
        idle(2);
        dreq = 4'b0000;
        rd(0); rd(10);

        // R10 clear bit
        wr(6, 'h44); wr(1, 9);
        wr(0, 'h14);
        rd(0); rd(1); rd(6); rd(7);
        dreq = 4'b1000; idle(2); dreq = 4'b0000;

        // R8 arm with zero count, ch0
        wr(9, 0); wr(0, 'h04); rd(1);
        wr(0, 'h09);
        rd(0); rd(10); idle(2);
        wr(0, 'h00); idle(2);

        // R12 external lines
        irq_in = 2'b01; idle(3);
        irq_in = 2'b10; idle(2);
        irq_in = 2'b00; idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            vecs++;
            miss++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end
endmodule